// File: doc/BRIEF.md
# Bus Error Status Register

This block records why a memory access failed. It takes fault strobes from two places. The address translation stage reports a page that is not mapped and an access that the page's protection does not allow. The downstream buses report an access to an address that does not exist, a generic failure and byte-lane parity errors. Each downstream fault also carries the bus type and the physical address of the access.

The block folds each fault into an 8-bit status code and holds it in a register that the processor reads. The block also decides whether a downstream fault is suppressed. On-board I/O never reports errors, and on-board memory below a configurable physical address does not report them either. A suppressed fault raises no error and leaves the register untouched. Instead it tells the requester to complete the read with all-ones data.

The error indication and the all-ones indication are one-cycle pulses. Each pulse is asserted in the same cycle in which the register takes its new value.

Top module: `berr_status_reg`

## Requirements
- R1: After reset the status register reads 0x00 and both the error pulse and the all-ones pulse are low.
- R2: An unmapped-page strobe loads the status register with 0x08 (only bit 3, protection error, set) and raises the error pulse.
- R3: A protection-violation strobe loads 0x88 (bit 7, map valid, and bit 3 set) and raises the error pulse.
- R4: An unsuppressed downstream fault loads bit 7. When the nonexistent-address flag accompanies it, the block also sets bit 2 (timeout), giving 0x84; otherwise it loads 0x80.
- R5: The parity qualifiers of a downstream fault set bit 0 for the lower byte lane and bit 1 for the upper byte lane, together with the R4 code.
- R6: When the bus type is expansion memory (2) or expansion I/O (3) and the VME option is enabled, bit 6 is also set on top of the R4/R5 code.
- R7: A downstream fault with bus type on-board I/O (1) raises the all-ones pulse, raises no error pulse and leaves the status register unchanged.
- R8: A downstream fault with bus type on-board memory (0) is suppressed as in R7 when its physical address is below 0x700000. At or above that address it raises an error with the R4/R5 code.
- R9: Each loaded fault replaces the whole register and does not OR into it. With no fault strobe, the register holds its value indefinitely.
- R10: When strobes arrive in the same cycle, an unmapped-page strobe wins over a protection violation, and either translation strobe wins over a downstream fault.
- R11: The register update and the error or all-ones pulse both appear on the first clock edge after the strobe cycle. Each pulse lasts exactly one cycle per strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_unmapped_i | input | 1 | Translation found no valid page |
| xl_prot_i | input | 1 | Translation refused the access type |
| dn_fault_i | input | 1 | Downstream bus reported a failure |
| dn_noent_i | input | 1 | Qualifier: failure was a nonexistent address |
| dn_par_i | input | 2 | Qualifier: parity error per byte lane, bit 0 lower, bit 1 upper |
| dn_kind_i | input | 2 | Bus type: 0 on-board memory, 1 on-board I/O, 2 expansion memory, 3 expansion I/O |
| dn_addr_i | input | ADDR_W | Physical address of the downstream access |
| status_o | output | STAT_W | Captured fault code |
| berr_o | output | 1 | Error pulse to the requester |
| ones_o | output | 1 | Complete the read with all-ones data, no error |

## Verification
The properties assume that the downstream qualifiers (nonexistent-address flag, parity bits, bus type and address) are meaningful only in a cycle where the downstream fault strobe is high. They also assume each strobe is a clean synchronous level sampled at a rising edge. The bench drives every strobe for exactly one cycle from the falling edge and drops all strobes and qualifiers to zero on the next falling edge. Concurrent strobes occur only in the dedicated priority scenario, where all qualifiers are held at defined values.

// File: rtl/berr_pkg.sv
package berr_pkg;
   typedef enum logic [1:0] {
      KIND_LOCAL_MEM = 2'd0,
      KIND_LOCAL_IO  = 2'd1,
      KIND_EXP_MEM   = 2'd2,
      KIND_EXP_IO    = 2'd3
   } bus_kind_e;

   // bit positions of the status code, read by software
   localparam int BIT_PAR_LO = 0;
   localparam int BIT_PAR_HI = 1;
   localparam int BIT_TMO    = 2;
   localparam int BIT_PROT   = 3;
   localparam int BIT_XBUS   = 6;
   localparam int BIT_MAPOK  = 7;
   localparam int CODE_BITS  = 8;
endpackage

// File: rtl/berr_quiet.sv
// Decides whether a downstream fault is swallowed (all-ones read, no error).
module berr_quiet #(
   parameter int          ADDR_W      = 24,
   parameter logic [31:0] QUIET_LIMIT = 32'h0070_0000
) (
   input  logic [1:0]        kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              quiet_o
);
   import berr_pkg::*;

   localparam logic [ADDR_W-1:0] LIMIT_A = QUIET_LIMIT[ADDR_W-1:0];

   logic low_mem;

   assign low_mem = (addr_i < LIMIT_A);

   always_comb begin
      unique case (bus_kind_e'(kind_i))
         KIND_LOCAL_IO:  quiet_o = 1'b1;
         KIND_LOCAL_MEM: quiet_o = low_mem;
         default:        quiet_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/berr_code.sv
// Builds the status code for the winning fault source.
module berr_code #(
   parameter int STAT_W  = 8,
   parameter bit HAS_VME = 1'b1
) (
   input  logic              unmapped_i,
   input  logic              prot_i,
   input  logic              noent_i,
   input  logic [1:0]        par_i,
   input  logic [1:0]        kind_i,
   output logic [STAT_W-1:0] code_o
);
   import berr_pkg::*;

   logic xbus;

   generate
      if (HAS_VME) begin : g_vme
         assign xbus = kind_i[1];
      end else begin : g_novme
         assign xbus = 1'b0;
      end
   endgenerate

   always_comb begin
      code_o = '0;
      if (unmapped_i) begin
         code_o[BIT_PROT] = 1'b1;
      end else if (prot_i) begin
         code_o[BIT_PROT]  = 1'b1;
         code_o[BIT_MAPOK] = 1'b1;
      end else begin
         code_o[BIT_MAPOK]  = 1'b1;
         code_o[BIT_TMO]    = noent_i;
         code_o[BIT_PAR_LO] = par_i[0];
         code_o[BIT_PAR_HI] = par_i[1];
         code_o[BIT_XBUS]   = xbus;
      end
   end
endmodule

// File: rtl/berr_status_reg.sv
module berr_status_reg #(
   parameter int          STAT_W      = 8,
   parameter int          ADDR_W      = 24,
   parameter logic [31:0] QUIET_LIMIT = 32'h0070_0000,
   parameter bit          HAS_VME     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xl_unmapped_i,
   input  logic              xl_prot_i,
   input  logic              dn_fault_i,
   input  logic              dn_noent_i,
   input  logic [1:0]        dn_par_i,
   input  logic [1:0]        dn_kind_i,
   input  logic [ADDR_W-1:0] dn_addr_i,
   output logic [STAT_W-1:0] status_o,
   output logic              berr_o,
   output logic              ones_o
);
   import berr_pkg::*;

   generate
      if (STAT_W < CODE_BITS) begin : g_bad_width
         $error("STAT_W must hold the 8-bit fault code");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must be 1..32");
      end
   endgenerate

   logic              xl_hit;
   logic              dn_hit;
   logic              quiet;
   logic              load;
   logic [STAT_W-1:0] code;

   assign xl_hit = xl_unmapped_i | xl_prot_i;
   assign dn_hit = dn_fault_i & ~xl_hit;
   assign load   = xl_hit | (dn_hit & ~quiet);

   berr_quiet #(
      .ADDR_W      (ADDR_W),
      .QUIET_LIMIT (QUIET_LIMIT)
   ) u_quiet (
      .kind_i  (dn_kind_i),
      .addr_i  (dn_addr_i),
      .quiet_o (quiet)
   );

   berr_code #(
      .STAT_W  (STAT_W),
      .HAS_VME (HAS_VME)
   ) u_code (
      .unmapped_i (xl_unmapped_i),
      .prot_i     (xl_prot_i),
      .noent_i    (dn_noent_i),
      .par_i      (dn_par_i),
      .kind_i     (dn_kind_i),
      .code_o     (code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_o <= '0;
         berr_o   <= 1'b0;
         ones_o   <= 1'b0;
      end else begin
         berr_o <= load;
         ones_o <= dn_hit & quiet;
         if (load) status_o <= code;
      end
   end
endmodule

// File: rtl/berr_status_chk.sv
module berr_status_chk #(
   parameter int STAT_W  = 8,
   parameter bit HAS_VME = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xl_unmapped_i,
   input logic              xl_prot_i,
   input logic              dn_fault_i,
   input logic [1:0]        dn_kind_i,
   input logic [STAT_W-1:0] status_o,
   input logic              berr_o,
   input logic              ones_o
);
   p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xl_unmapped_i |=> (status_o[7:0] == 8'h08) && berr_o);

   p_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_prot_i && !xl_unmapped_i) |=> (status_o[7:0] == 8'h88) && berr_o);

   p_localio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_fault_i && !xl_unmapped_i && !xl_prot_i && dn_kind_i == 2'd1)
      |=> ones_o && !berr_o && $stable(status_o));

   p_xbus_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_fault_i && !xl_unmapped_i && !xl_prot_i && dn_kind_i[1])
      |=> berr_o && (status_o[6] == HAS_VME) && status_o[7]);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(xl_unmapped_i || xl_prot_i || dn_fault_i) |=> $stable(status_o) && !berr_o && !ones_o);

   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(berr_o && ones_o));
endmodule

bind berr_status_reg berr_status_chk #(
   .STAT_W  (STAT_W),
   .HAS_VME (HAS_VME)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .xl_unmapped_i (xl_unmapped_i),
   .xl_prot_i     (xl_prot_i),
   .dn_fault_i    (dn_fault_i),
   .dn_kind_i     (dn_kind_i),
   .status_o      (status_o),
   .berr_o        (berr_o),
   .ones_o        (ones_o)
);

// File: tb/tb_berr_status_reg.sv
`timescale 1ns/1ps
module tb_berr_status_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        unm = 1'b0, prot = 1'b0, flt = 1'b0, noent = 1'b0;
   logic [1:0]  par = 2'b00, kind = 2'b00;
   logic [23:0] addr = '0;
   logic [7:0]  status;
   logic        berr, ones;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   berr_status_reg dut (
      .clk(clk), .rst_n(rst_n),
      .xl_unmapped_i(unm), .xl_prot_i(prot),
      .dn_fault_i(flt), .dn_noent_i(noent), .dn_par_i(par),
      .dn_kind_i(kind), .dn_addr_i(addr),
      .status_o(status), .berr_o(berr), .ones_o(ones)
   );

   task automatic check(string req, logic [7:0] exp_s, logic exp_b, logic exp_o);
      checks++;
      if (status !== exp_s || berr !== exp_b || ones !== exp_o) begin
         errors++;
         $display("FAIL %s: status=%h berr=%b ones=%b expected status=%h berr=%b ones=%b",
                  req, status, berr, ones, exp_s, exp_b, exp_o);
      end
   endtask

   // one-cycle strobe; returns at the falling edge where the result is visible
   task automatic strobe(logic u, logic p, logic f, logic n, logic [1:0] pr,
                         logic [1:0] k, logic [23:0] a);
      @(negedge clk);
      unm = u; prot = p; flt = f; noent = n; par = pr; kind = k; addr = a;
      @(negedge clk);
      unm = 0; prot = 0; flt = 0; noent = 0; par = 0; kind = 0; addr = 0;
   endtask

   task automatic t_reset;
      check("R1", 8'h00, 1'b0, 1'b0);
   endtask

   task automatic t_unmapped;
      strobe(1, 0, 0, 0, 2'b00, 2'd0, 24'h0);
      check("R2", 8'h08, 1'b1, 1'b0);
   endtask

   task automatic t_prot;
      strobe(0, 1, 0, 0, 2'b00, 2'd0, 24'h0);
      check("R3", 8'h88, 1'b1, 1'b0);
   endtask

   task automatic t_downstream;
      strobe(0, 0, 1, 1, 2'b00, 2'd0, 24'h700000);
      check("R4 noent", 8'h84, 1'b1, 1'b0);
      strobe(0, 0, 1, 0, 2'b00, 2'd0, 24'h7FFFFE);
      check("R4 generic", 8'h80, 1'b1, 1'b0);
   endtask

   task automatic t_parity;
      strobe(0, 0, 1, 0, 2'b01, 2'd0, 24'hF00000);
      check("R5 lower", 8'h81, 1'b1, 1'b0);
      strobe(0, 0, 1, 1, 2'b10, 2'd0, 24'hF00000);
      check("R5 upper", 8'h86, 1'b1, 1'b0);
   endtask

   task automatic t_vme;
      strobe(0, 0, 1, 0, 2'b00, 2'd2, 24'h000100);
      check("R6 expmem", 8'hC0, 1'b1, 1'b0);
      strobe(0, 0, 1, 1, 2'b00, 2'd3, 24'h000100);
      check("R6 expio", 8'hC4, 1'b1, 1'b0);
   endtask

   task automatic t_local_io;
      strobe(1, 0, 0, 0, 2'b00, 2'd0, 24'h0);
      check("R7 preload", 8'h08, 1'b1, 1'b0);
      strobe(0, 0, 1, 1, 2'b11, 2'd1, 24'hFFFFFF);
      check("R7 local io", 8'h08, 1'b0, 1'b1);
   endtask

   task automatic t_local_mem;
      strobe(0, 0, 1, 1, 2'b00, 2'd0, 24'h6FFFFF);
      check("R8 below", 8'h08, 1'b0, 1'b1);
      strobe(0, 0, 1, 1, 2'b00, 2'd0, 24'h700000);
      check("R8 at limit", 8'h84, 1'b1, 1'b0);
   endtask

   task automatic t_overwrite;
      strobe(0, 0, 1, 1, 2'b11, 2'd3, 24'h0);
      check("R9 full", 8'hC7, 1'b1, 1'b0);
      strobe(1, 0, 0, 0, 2'b00, 2'd0, 24'h0);
      check("R9 replace", 8'h08, 1'b1, 1'b0);
      for (int i = 0; i < 5; i++) @(negedge clk);
      check("R9 hold", 8'h08, 1'b0, 1'b0);
   endtask

   task automatic t_priority;
      strobe(1, 1, 1, 1, 2'b11, 2'd3, 24'h0);
      check("R10 unmapped wins", 8'h08, 1'b1, 1'b0);
      strobe(0, 1, 1, 1, 2'b11, 2'd1, 24'h0);
      check("R10 prot wins", 8'h88, 1'b1, 1'b0);
   endtask

   task automatic t_timing;
      strobe(0, 0, 1, 0, 2'b00, 2'd2, 24'h0);
      check("R11 pulse", 8'hC0, 1'b1, 1'b0);
      @(negedge clk);
      check("R11 pulse ends", 8'hC0, 1'b0, 1'b0);
      strobe(0, 0, 1, 0, 2'b00, 2'd1, 24'h0);
      check("R11 ones pulse", 8'hC0, 1'b0, 1'b1);
      @(negedge clk);
      check("R11 ones ends", 8'hC0, 1'b0, 1'b0);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unmapped();
      t_prot();
      t_downstream();
      t_parity();
      t_vme();
      t_local_io();
      t_local_mem();
      t_overwrite();
      t_priority();
      t_timing();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule